// File: doc/BRIEF.md
# Period-Locked Sine Synthesizer

The block produces a stream of 10-bit sine samples whose period follows an integer period setting. That setting is also used by a companion pulse generator. The period arrives in units of 0.1 us. The block runs from a 50 MHz clock, so one period unit spans five clock cycles.

From the period the block derives a phase increment, 2^32 / (5·T). It works this out with a bit-serial divider whenever the setting changes, and keeps the previous increment running while the division is in progress. A 32-bit phase register adds the increment on every clock. Its ten most significant bits select an entry in a sine table of 1024 offset-binary codes, and that table is computed when the design is built. When the period setting is zero, the sample output is held at zero. A one-cycle flag marks each moment a newly derived increment takes over.

Top module: `period_sine_dds`

## Requirements
- R1: While reset is asserted, and after its release, the phase and the phase increment are zero and `word_valid` is low. `sample_out` is zero right after release. For a nonzero period it then settles to the table entry for phase zero, code 512, until a derived increment arrives.
- R2: The increment derived for a nonzero period T is floor(2^32 / (5·T)), rounded down. This holds over the whole range, from T = 1 up to T = 131071.
- R3: The rising edge that first samples a new nonzero T counts as edge 1. The new increment is loaded at edge 34, and `word_valid` is high for exactly the one cycle that follows that edge. The phase register uses the new increment from edge 35 onward.
- R4: Until a pending increment is loaded, the previous increment stays in use. A change of T before the load discards the pending computation and starts a fresh one at the edge that samples the change. A change to zero cancels the computation without loading anything.
- R5: On every rising edge the phase register adds the current increment, modulo 2^32. On each edge `sample_out` takes the table entry addressed by phase bits [31:22] as they stood before that edge.
- R6: Table entry k (0..1023) holds the code floor(512 + 511·sin(2πk/1024) + 0.5). A sample that is not muted is therefore never zero.
- R7: When `period_in` is zero at a rising edge, `sample_out` is zero after that edge. The phase keeps advancing by the retained increment, and no `word_valid` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, nominally 50 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_in | input | 17 | Period T in 0.1 us units; zero mutes the output |
| sample_out | output | 10 | Offset-binary sine sample, registered |
| word_valid | output | 1 | One-cycle pulse when a new phase increment takes effect |

## Verification
The assertions take for granted that `period_in` is synchronous to `clk` and that a value held long enough eventually completes its division. The single-cycle valid pulse and the word-hold property rely on no new load occurring within 34 edges of the previous one. The stimulus changes the period only between clock edges, on a step of its own. It covers settings that restart a division part-way through, repeats of an unchanged value, the mute value, and both extremes of the period range. The reference model tracks every change with its own countdown.

// File: rtl/sdds_pkg.sv
package sdds_pkg;

   typedef enum logic [0:0] {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_t;

   // Offset-binary sine code for table slot k, rounded to nearest.
   function automatic int sine_code(int k, int addr_w, int out_w);
      real mid;
      real ang;
      real val;
      mid = 2.0 ** (out_w - 1);
      ang = 2.0 * 3.141592653589793 * k / (2.0 ** addr_w);
      val = mid + (mid - 1.0) * $sin(ang) + 0.5;
      return $rtoi(val);
   endfunction

endpackage

// File: rtl/sdds_div.sv
module sdds_div #(
   parameter int T_W        = 17,
   parameter int ACC_W      = 32,
   parameter int UNIT_TICKS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [T_W-1:0]   period,
   output logic [ACC_W-1:0] tw,
   output logic             tw_valid
);
   import sdds_pkg::*;

   localparam int DIV_W  = T_W + $clog2(UNIT_TICKS + 1);
   localparam int LAST   = ACC_W;
   localparam int STEP_W = $clog2(ACC_W + 1);

   div_state_t        state;
   logic [T_W-1:0]    seen;
   logic [STEP_W-1:0] step;
   logic [DIV_W-1:0]  rem;
   logic [DIV_W-1:0]  divisor;
   logic [ACC_W-1:0]  quo;

   logic [DIV_W:0]    rem_ext;
   logic [DIV_W:0]    diff;
   logic              ge;
   logic [DIV_W-1:0]  rem_nxt;
   logic [ACC_W-1:0]  quo_nxt;

   // Dividend is 2^ACC_W: a single one in the first step, zeros after.
   always_comb begin
      rem_ext = {rem, (step == '0)};
      diff    = rem_ext - {1'b0, divisor};
      ge      = (rem_ext >= {1'b0, divisor});
      rem_nxt = ge ? diff[DIV_W-1:0] : rem_ext[DIV_W-1:0];
      quo_nxt = {quo[ACC_W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= DIV_IDLE;
         seen     <= '0;
         step     <= '0;
         rem      <= '0;
         divisor  <= '0;
         quo      <= '0;
         tw       <= '0;
         tw_valid <= 1'b0;
      end else begin
         tw_valid <= 1'b0;
         if (period != seen) begin
            seen    <= period;
            step    <= '0;
            rem     <= '0;
            quo     <= '0;
            divisor <= DIV_W'(period) * DIV_W'(UNIT_TICKS);
            state   <= (period != '0) ? DIV_RUN : DIV_IDLE;
         end else if (state == DIV_RUN) begin
            rem  <= rem_nxt;
            quo  <= quo_nxt;
            step <= step + 1'b1;
            if (step == STEP_W'(LAST)) begin
               tw       <= quo_nxt;
               tw_valid <= 1'b1;
               state    <= DIV_IDLE;
            end
         end
      end
   end

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DIV_RUN) |-> (step <= STEP_W'(LAST)));                      // R3
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tw_valid |-> $stable(tw));                                            // R4
   AST_WORD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tw_valid |-> (tw != '0));                                              // R2

endmodule

// File: rtl/sdds_phase.sv
module sdds_phase #(
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  tw,
   output logic [ADDR_W-1:0] addr
);
   logic [ACC_W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + tw;
   end

   assign addr = phase[ACC_W-1 -: ADDR_W];

endmodule

// File: rtl/sdds_rom.sv
module sdds_rom #(
   parameter int ADDR_W = 10,
   parameter int OUT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mute,
   output logic [OUT_W-1:0]  sample
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [OUT_W-1:0] tbl [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
      localparam int CODE = sdds_pkg::sine_code(gi, ADDR_W, OUT_W);
      assign tbl[gi] = CODE[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sample <= '0;
      else if (mute) sample <= '0;
      else           sample <= tbl[addr];
   end

   AST_LIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mute |=> (sample != '0));                                             // R6

endmodule

// File: rtl/period_sine_dds.sv
module period_sine_dds #(
   parameter int T_W        = 17,
   parameter int ACC_W      = 32,
   parameter int ADDR_W     = 10,
   parameter int OUT_W      = 10,
   parameter int UNIT_TICKS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [T_W-1:0]    period_in,
   output logic [OUT_W-1:0]  sample_out,
   output logic              word_valid
);
   if (ADDR_W > ACC_W) begin : g_bad_addr
      $error("ADDR_W must not exceed ACC_W");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("OUT_W must be at least 2");
   end
   if (UNIT_TICKS < 1) begin : g_bad_ticks
      $error("UNIT_TICKS must be at least 1");
   end
   if (ACC_W < 2) begin : g_bad_acc
      $error("ACC_W must be at least 2");
   end

   logic [ACC_W-1:0]  tw;
   logic [ADDR_W-1:0] addr;
   logic              mute;

   assign mute = (period_in == '0);

   sdds_div #(.T_W(T_W), .ACC_W(ACC_W), .UNIT_TICKS(UNIT_TICKS)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .period   (period_in),
      .tw       (tw),
      .tw_valid (word_valid)
   );

   sdds_phase #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .tw    (tw),
      .addr  (addr)
   );

   sdds_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .mute   (mute),
      .sample (sample_out)
   );

   AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (period_in == '0) |=> (sample_out == '0));                             // R7
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);                                           // R3

endmodule

// File: tb/sim_period_sine_dds.sv
module sim_period_sine_dds;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [16:0] period_in;
   wire  [9:0]  sample_out;
   wire         word_valid;

   always #5 clk = ~clk;

   period_sine_dds u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_in  (period_in),
      .sample_out (sample_out),
      .word_valid (word_valid)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R1";

   // reference state
   bit [31:0] m_phase;
   bit [31:0] m_tw;
   bit [31:0] m_pend;
   bit [16:0] m_seen;
   int        m_cnt;

   function automatic int ref_sine(int k);
      real a;
      a = 2.0 * 3.141592653589793 * k / 1024.0;
      return $rtoi(512.0 + 511.0 * $sin(a) + 0.5);
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      bit [16:0] t;
      int        exp_s;
      bit        exp_v;
      longint    q;
      @(posedge clk);
      t = period_in;
      #1;
      exp_s = (t == 0) ? 0 : ref_sine(int'(m_phase >> 22));
      m_phase = m_phase + m_tw;
      exp_v = 1'b0;
      if (t != m_seen) begin
         m_seen = t;
         if (t != 0) begin
            q = (longint'(1) << 32) / (longint'(5) * longint'(t));
            m_pend = q[31:0];
            m_cnt = 33;
         end else begin
            m_cnt = 0;
         end
      end else if (m_cnt > 0) begin
         m_cnt--;
         if (m_cnt == 0) begin
            m_tw = m_pend;
            exp_v = 1'b1;
         end
      end
      check((t == 0) ? "R7" : cur_tag, int'(sample_out), exp_s);
      check("R3", int'(word_valid), int'(exp_v));
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R1 actual=running expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      period_in = '0;
      m_phase = '0; m_tw = '0; m_pend = '0; m_seen = '0; m_cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", int'(sample_out), 0);
      check("R1", int'(word_valid), 0);
      rst_n = 1'b1;
      cur_tag = "R1";
      run(5);
      period_in = 17'd1;
      run(20);
      cur_tag = "R3";
      run(20);
      cur_tag = "R2";
      run(300);
      cur_tag = "R5";
      period_in = 17'd100;
      run(600);
      cur_tag = "R4";
      period_in = 17'd7;
      run(10);
      period_in = 17'd3000;
      run(60);
      period_in = 17'd3000;
      run(100);
      period_in = 17'd9;
      run(20);
      period_in = '0;
      cur_tag = "R7";
      run(50);
      cur_tag = "R4";
      period_in = 17'd50;
      run(100);
      cur_tag = "R2";
      period_in = 17'd131071;
      run(200);
      cur_tag = "R6";
      period_in = 17'd2;
      run(1200);
      cur_tag = "R5";
      period_in = 17'd3;
      run(300);
      finish_run();
   end

endmodule